// File: doc/BRIEF.md
# Character Display Instruction Executor

This block runs the command set of a character display controller. The host writes an 8-bit instruction code, a data byte to store, or a read request. The block decodes the code and updates its control state. That state is the address counter, the memory select, the entry-mode bits, the display/cursor/blink bits, the function bits and a display shift offset. The block drives an external port to display-data and character-generator memory, and it holds a busy flag for a fixed number of clock cycles per command.

The clear-display command sweeps the whole display-data space with the space code. The sweep runs inside the command's long busy window, one location per clock. Data transfers move the address counter by one in the chosen direction, and in two-line mode the counter follows the line boundaries. While busy is high, requests have no effect and are counted. Execution times are counted in clock cycles, so they scale with the oscillator frequency.

Top module: `chr_disp_exec`

## Requirements
- R1: After reset: ac_o=0, cg_sel_o=0, shift_o=0, busy_o=0, drop_cnt_o=0, inc_o=1, auto_shift_o=0, disp_on_o=cursor_on_o=blink_o=0, func_o=4'b1011 ({DL,N,E1,E0}).
- R2: The instruction code is decoded by the position of its highest set bit: bit0 clear, bit1 home, bit2 entry mode, bit3 display control, bit4 shift, bit5 function set, bit6 CG address, bit7 DD address; code 0x00 is a no-op with the short busy time.
- R3: Clear writes 0x20 to every display-data address 0x00..0x7F, one per cycle, all within its busy window. It also sets ac_o=0, cg_sel_o=0, shift_o=0 and inc_o=1.
- R4: Return home sets ac_o=0, cg_sel_o=0 and shift_o=0, and performs no memory write.
- R5: Entry mode latches inc_o=bit1 and auto_shift_o=bit0. Display control latches disp_on_o=bit2, cursor_on_o=bit1 and blink_o=bit0. Function set latches func_o={bit4,bit3,bit1,bit0}.
- R6: A data write stores dw_data_i at ac_o in the selected memory, then steps ac_o (+1 if inc_o=1, else -1). With auto_shift_o=1 the offset also moves: +1 (left) when inc_o=1, -1 (right) when inc_o=0.
- R7: A data read returns the selected memory's byte at ac_o on dr_data_o after the accepting edge, then steps ac_o like a write. It never changes shift_o.
- R8: Shift with bit3=0 moves ac_o one step (right when bit2=1, left when bit2=0). Shift with bit3=1 changes only shift_o: -1 when bit2=1 (right), +1 when bit2=0 (left).
- R9: CG address sets ac_o={0,code[5:0]} and cg_sel_o=1. DD address sets ac_o=code[6:0] and cg_sel_o=0.
- R10: Address steps in DD with func N=0 go 0x27→0x40, 0x67→0x00, 0x00→0x67 and 0x40→0x27. With N=1 they wrap within 7 bits. In CG they wrap within 6 bits.
- R11: busy_o is high for exactly CYC_LONG (409) cycles after clear/home, CYC_MID (15) after shift and data read, and CYC_SHORT (10) after any other command. The count starts at the accepting edge.
- R12: A request seen while busy_o=1 has no effect and adds one to the saturating drop_cnt_o. Of simultaneous requests, priority is instruction, then write, then read, and each loser is counted.
- R13: shift_o stays within 0..LINE_LEN-1 (39) and wraps at both ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | oscillator clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| ir_we_i | input | 1 | instruction write strobe |
| ir_data_i | input | 8 | instruction code |
| dw_we_i | input | 1 | data write strobe |
| dw_data_i | input | 8 | data byte to store |
| dr_re_i | input | 1 | data read strobe |
| dr_data_o | output | 8 | last byte read |
| mem_we_o | output | 1 | memory write enable |
| mem_cg_o | output | 1 | memory select, 1 = character generator |
| mem_addr_o | output | 7 | memory address |
| mem_wdata_o | output | 8 | memory write data |
| mem_rdata_i | input | 8 | memory read data, combinational from address |
| busy_o | output | 1 | command in progress |
| ac_o | output | 7 | address counter |
| cg_sel_o | output | 1 | counter targets character-generator memory |
| shift_o | output | 6 | display shift offset |
| inc_o | output | 1 | step direction, 1 = increment |
| auto_shift_o | output | 1 | shift display on writes |
| disp_on_o | output | 1 | display enable |
| cursor_on_o | output | 1 | cursor enable |
| blink_o | output | 1 | blink enable |
| func_o | output | 4 | {DL,N,E1,E0} |
| drop_cnt_o | output | 8 | saturating count of ignored requests |

## Verification
Two cases are hard to reach from the ports. One is a request that lands inside the busy window. The other is a step across a line boundary in two-line mode. For the first, the bench pulses a DD address write and a data write during the 409-cycle window of a clear, and also presents an instruction and a write on the same cycle. It then checks that the counter and memory are unchanged and that the drop count rose by the right amount. For the second, the bench places the counter on each of the four boundary addresses and steps it with writes and cursor shifts. A seeded random run mixing every command then compares all state against a bench model after each command.

// File: rtl/chr_disp_pkg.sv
package chr_disp_pkg;
  typedef enum logic [3:0] {
    OP_NOP, OP_CLEAR, OP_HOME, OP_ENTRY, OP_DISP,
    OP_SHIFT, OP_FUNC, OP_CGADR, OP_DDADR
  } op_e;

  typedef enum logic [1:0] {T_SHORT, T_MID, T_LONG} tcls_e;
endpackage

// File: rtl/chr_op_decode.sv
module chr_op_decode
  import chr_disp_pkg::*;
(
  input  logic [7:0] code_i,
  output op_e        op_o,
  output tcls_e      tcls_o
);
  logic [3:0] hi;

  always_comb begin
    hi = '0;
    for (int i = 0; i < 8; i++) begin
      if (code_i[i]) hi = 4'(i + 1);
    end
  end

  always_comb begin
    case (hi)
      4'd1:    op_o = OP_CLEAR;
      4'd2:    op_o = OP_HOME;
      4'd3:    op_o = OP_ENTRY;
      4'd4:    op_o = OP_DISP;
      4'd5:    op_o = OP_SHIFT;
      4'd6:    op_o = OP_FUNC;
      4'd7:    op_o = OP_CGADR;
      4'd8:    op_o = OP_DDADR;
      default: op_o = OP_NOP;
    endcase
    case (op_o)
      OP_CLEAR, OP_HOME: tcls_o = T_LONG;
      OP_SHIFT:          tcls_o = T_MID;
      default:           tcls_o = T_SHORT;
    endcase
  end
endmodule

// File: rtl/chr_busy_timer.sv
module chr_busy_timer
  import chr_disp_pkg::*;
#(
  parameter int CYC_LONG  = 409,
  parameter int CYC_MID   = 15,
  parameter int CYC_SHORT = 10,
  localparam int CNT_W    = $clog2(CYC_LONG + 1)
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  start_i,
  input  tcls_e tcls_i,
  output logic  busy_o
);
  logic [CNT_W-1:0] cnt_q, load;

  always_comb begin
    case (tcls_i)
      T_LONG:  load = CNT_W'(CYC_LONG);
      T_MID:   load = CNT_W'(CYC_MID);
      default: load = CNT_W'(CYC_SHORT);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (start_i)      cnt_q <= load;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  a_r11_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(CYC_LONG));
  a_r11_counts_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !start_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/chr_addr_step.sv
module chr_addr_step #(
  parameter int AW         = 7,
  parameter int CG_AW      = 6,
  parameter int LINE_LEN   = 40,
  parameter int LINE2_BASE = 64
) (
  input  logic [AW-1:0] ac_i,
  input  logic          up_i,
  input  logic          cg_i,
  input  logic          four_line_i,
  output logic [AW-1:0] nxt_o
);
  localparam logic [AW-1:0] L1_END   = AW'(LINE_LEN - 1);
  localparam logic [AW-1:0] L2_START = AW'(LINE2_BASE);
  localparam logic [AW-1:0] L2_END   = AW'(LINE2_BASE + LINE_LEN - 1);

  logic [CG_AW-1:0] cg_nxt;
  logic [AW-1:0]    dd_nxt;

  assign cg_nxt = up_i ? ac_i[CG_AW-1:0] + 1'b1 : ac_i[CG_AW-1:0] - 1'b1;

  always_comb begin
    dd_nxt = up_i ? ac_i + 1'b1 : ac_i - 1'b1;
    if (!four_line_i) begin
      if (up_i) begin
        if (ac_i == L1_END)      dd_nxt = L2_START;
        else if (ac_i == L2_END) dd_nxt = '0;
      end else begin
        if (ac_i == '0)            dd_nxt = L2_END;
        else if (ac_i == L2_START) dd_nxt = L1_END;
      end
    end
  end

  generate
    if (AW > CG_AW) begin : g_pad
      assign nxt_o = cg_i ? {{(AW-CG_AW){1'b0}}, cg_nxt} : dd_nxt;
    end else begin : g_nopad
      assign nxt_o = cg_i ? cg_nxt[AW-1:0] : dd_nxt;
    end
  endgenerate
endmodule

// File: rtl/chr_disp_exec.sv
module chr_disp_exec
  import chr_disp_pkg::*;
#(
  parameter int CYC_LONG   = 409,
  parameter int CYC_MID    = 15,
  parameter int CYC_SHORT  = 10,
  parameter int LINE_LEN   = 40,
  parameter int LINE2_BASE = 64,
  parameter int DROP_W     = 8,
  localparam int AW        = 7,
  localparam int CG_AW     = 6,
  localparam int LW        = $clog2(LINE_LEN),
  localparam int DD_DEPTH  = 1 << AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ir_we_i,
  input  logic [7:0]        ir_data_i,
  input  logic              dw_we_i,
  input  logic [7:0]        dw_data_i,
  input  logic              dr_re_i,
  output logic [7:0]        dr_data_o,
  output logic              mem_we_o,
  output logic              mem_cg_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i,
  output logic              busy_o,
  output logic [AW-1:0]     ac_o,
  output logic              cg_sel_o,
  output logic [LW-1:0]     shift_o,
  output logic              inc_o,
  output logic              auto_shift_o,
  output logic              disp_on_o,
  output logic              cursor_on_o,
  output logic              blink_o,
  output logic [3:0]        func_o,
  output logic [DROP_W-1:0] drop_cnt_o
);
  op_e   op;
  tcls_e op_tcls, tcls;
  logic  busy;
  logic  take_ir, take_wr, take_rd, start;
  logic  step_up;
  logic [AW-1:0] ac_q, ac_step;
  logic          cg_q, inc_q, s_q, d_q, c_q, b_q;
  logic [3:0]    func_q;
  logic [LW-1:0] shift_q, sh_plus, sh_minus;
  logic [7:0]    rdata_q;
  logic          clr_active;
  logic [AW-1:0] clr_idx;
  logic [1:0]    n_req, n_drop;
  logic [DROP_W-1:0] drop_q;
  logic [DROP_W:0]   drop_sum;

  chr_op_decode u_dec (.code_i(ir_data_i), .op_o(op), .tcls_o(op_tcls));

  assign take_ir = ir_we_i & ~busy;
  assign take_wr = dw_we_i & ~ir_we_i & ~busy;
  assign take_rd = dr_re_i & ~ir_we_i & ~dw_we_i & ~busy;
  assign start   = take_ir | take_wr | take_rd;
  assign tcls    = take_ir ? op_tcls : (take_rd ? T_MID : T_SHORT);

  chr_busy_timer #(
    .CYC_LONG(CYC_LONG), .CYC_MID(CYC_MID), .CYC_SHORT(CYC_SHORT)
  ) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .tcls_i(tcls), .busy_o(busy)
  );

  // cursor shift uses R/L, data transfers use the entry direction
  assign step_up = take_ir ? ir_data_i[2] : inc_q;

  chr_addr_step #(
    .AW(AW), .CG_AW(CG_AW), .LINE_LEN(LINE_LEN), .LINE2_BASE(LINE2_BASE)
  ) u_step (
    .ac_i(ac_q), .up_i(step_up), .cg_i(cg_q), .four_line_i(func_q[2]), .nxt_o(ac_step)
  );

  assign sh_plus  = (shift_q == LW'(LINE_LEN - 1)) ? '0 : shift_q + 1'b1;
  assign sh_minus = (shift_q == '0) ? LW'(LINE_LEN - 1) : shift_q - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ac_q    <= '0;
      cg_q    <= 1'b0;
      inc_q   <= 1'b1;
      s_q     <= 1'b0;
      d_q     <= 1'b0;
      c_q     <= 1'b0;
      b_q     <= 1'b0;
      func_q  <= 4'b1011;
      shift_q <= '0;
      rdata_q <= '0;
    end else if (take_ir) begin
      case (op)
        OP_CLEAR: begin
          ac_q <= '0; cg_q <= 1'b0; shift_q <= '0; inc_q <= 1'b1;
        end
        OP_HOME: begin
          ac_q <= '0; cg_q <= 1'b0; shift_q <= '0;
        end
        OP_ENTRY: begin
          inc_q <= ir_data_i[1]; s_q <= ir_data_i[0];
        end
        OP_DISP: begin
          d_q <= ir_data_i[2]; c_q <= ir_data_i[1]; b_q <= ir_data_i[0];
        end
        OP_SHIFT: begin
          if (ir_data_i[3]) shift_q <= ir_data_i[2] ? sh_minus : sh_plus;
          else              ac_q    <= ac_step;
        end
        OP_FUNC:  func_q <= {ir_data_i[4], ir_data_i[3], ir_data_i[1], ir_data_i[0]};
        OP_CGADR: begin
          ac_q <= {{(AW-CG_AW){1'b0}}, ir_data_i[CG_AW-1:0]}; cg_q <= 1'b1;
        end
        OP_DDADR: begin
          ac_q <= ir_data_i[AW-1:0]; cg_q <= 1'b0;
        end
        default: ;
      endcase
    end else if (take_wr) begin
      ac_q <= ac_step;
      if (s_q) shift_q <= inc_q ? sh_plus : sh_minus;
    end else if (take_rd) begin
      ac_q    <= ac_step;
      rdata_q <= mem_rdata_i;
    end
  end

  // clear sweep: one location per cycle inside the long busy window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clr_active <= 1'b0;
      clr_idx    <= '0;
    end else if (take_ir && op == OP_CLEAR) begin
      clr_active <= 1'b1;
      clr_idx    <= '0;
    end else if (clr_active) begin
      clr_idx <= clr_idx + 1'b1;
      if (clr_idx == AW'(DD_DEPTH - 1)) clr_active <= 1'b0;
    end
  end

  assign n_req  = 2'(ir_we_i) + 2'(dw_we_i) + 2'(dr_re_i);
  assign n_drop = busy ? n_req : ((n_req != '0) ? n_req - 1'b1 : '0);
  assign drop_sum = {1'b0, drop_q} + (DROP_W+1)'(n_drop);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                drop_q <= '0;
    else if (drop_sum[DROP_W])  drop_q <= '1;
    else                        drop_q <= drop_sum[DROP_W-1:0];
  end

  assign mem_we_o     = clr_active | take_wr;
  assign mem_cg_o     = clr_active ? 1'b0 : cg_q;
  assign mem_addr_o   = clr_active ? clr_idx : ac_q;
  assign mem_wdata_o  = clr_active ? 8'h20 : dw_data_i;
  assign dr_data_o    = rdata_q;
  assign busy_o       = busy;
  assign ac_o         = ac_q;
  assign cg_sel_o     = cg_q;
  assign shift_o      = shift_q;
  assign inc_o        = inc_q;
  assign auto_shift_o = s_q;
  assign disp_on_o    = d_q;
  assign cursor_on_o  = c_q;
  assign blink_o      = b_q;
  assign func_o       = func_q;
  assign drop_cnt_o   = drop_q;

  a_r12_busy_holds_ac: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> $stable(ac_q));
  a_r12_busy_holds_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> $stable(shift_q));
  a_r12_one_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({take_ir, take_wr, take_rd}));
  a_r12_drop_monotone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> drop_q >= $past(drop_q));
  a_r11_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> busy);
  a_r3_sweep_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_active |-> busy);
  a_r13_shift_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_q < LW'(LINE_LEN));
  a_r7_read_no_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_rd |=> $stable(shift_q));
endmodule

// File: tb/chr_disp_exec_tb_top.sv
module chr_disp_exec_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int T_LONG = 409, T_MID = 15, T_SHORT = 10, LLEN = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ir_we = 0, dw_we = 0, dr_re = 0;
  logic [7:0] ir_data = 0, dw_data = 0, dr_data, mem_wdata, mem_rdata;
  logic mem_we, mem_cg, busy, cg_sel, inc, ash, don, con, bon;
  logic [6:0] mem_addr, ac;
  logic [5:0] shift;
  logic [3:0] func;
  logic [7:0] drop;

  logic [7:0] mem_dd [128] = '{default: 8'h00};
  logic [7:0] mem_cg_a [64] = '{default: 8'h00};

  int total = 0, bad = 0;

  // bench model
  logic [6:0] e_ac = 0;
  logic e_cg = 0, e_inc = 1, e_s = 0, e_d = 0, e_c = 0, e_b = 0;
  logic [3:0] e_func = 4'b1011;
  int e_sh = 0, e_drop = 0;
  logic [7:0] e_dd [128] = '{default: 8'h00};
  logic [7:0] e_cgm [64] = '{default: 8'h00};

  always #(CLK_PERIOD/2) clk = ~clk;

  chr_disp_exec dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ir_we_i(ir_we), .ir_data_i(ir_data),
    .dw_we_i(dw_we), .dw_data_i(dw_data), .dr_re_i(dr_re), .dr_data_o(dr_data),
    .mem_we_o(mem_we), .mem_cg_o(mem_cg), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .busy_o(busy),
    .ac_o(ac), .cg_sel_o(cg_sel), .shift_o(shift), .inc_o(inc),
    .auto_shift_o(ash), .disp_on_o(don), .cursor_on_o(con), .blink_o(bon),
    .func_o(func), .drop_cnt_o(drop)
  );

  assign mem_rdata = mem_cg ? mem_cg_a[mem_addr[5:0]] : mem_dd[mem_addr];

  always @(posedge clk) begin
    if (mem_we) begin
      if (mem_cg) mem_cg_a[mem_addr[5:0]] <= mem_wdata;
      else        mem_dd[mem_addr] <= mem_wdata;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] f_step(logic [6:0] a, logic up, logic cg, logic four);
    if (cg) return {1'b0, up ? a[5:0] + 6'd1 : a[5:0] - 6'd1};
    if (!four) begin
      if (up) begin
        if (a == 7'h27) return 7'h40;
        if (a == 7'h67) return 7'h00;
      end else begin
        if (a == 7'h00) return 7'h67;
        if (a == 7'h40) return 7'h27;
      end
    end
    return up ? a + 7'd1 : a - 7'd1;
  endfunction

  function automatic int f_len(logic [7:0] code);
    if (code[7:2] == 0 && code[1:0] != 0) return T_LONG;
    if (code[7:5] == 0 && code[4]) return T_MID;
    return T_SHORT;
  endfunction

  task automatic model_ir(input logic [7:0] c);
    if (c[7]) begin e_ac = c[6:0]; e_cg = 0; end
    else if (c[6]) begin e_ac = {1'b0, c[5:0]}; e_cg = 1; end
    else if (c[5]) e_func = {c[4], c[3], c[1], c[0]};
    else if (c[4]) begin
      if (c[3]) e_sh = c[2] ? (e_sh + LLEN - 1) % LLEN : (e_sh + 1) % LLEN;
      else e_ac = f_step(e_ac, c[2], e_cg, e_func[2]);
    end
    else if (c[3]) begin e_d = c[2]; e_c = c[1]; e_b = c[0]; end
    else if (c[2]) begin e_inc = c[1]; e_s = c[0]; end
    else if (c[1]) begin e_ac = 0; e_cg = 0; e_sh = 0; end
    else if (c[0]) begin
      e_ac = 0; e_cg = 0; e_sh = 0; e_inc = 1;
      for (int i = 0; i < 128; i++) e_dd[i] = 8'h20;
    end
  endtask

  // kind: 0 instruction, 1 write, 2 read
  task automatic pulse(input int kind, input logic [7:0] v);
    @(negedge clk);
    ir_we = (kind == 0); dw_we = (kind == 1); dr_re = (kind == 2);
    ir_data = v; dw_data = v;
    @(negedge clk);
    ir_we = 0; dw_we = 0; dr_re = 0;
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  task automatic check_state(input string req);
    chk({req, " ac"}, ac, e_ac);
    chk({req, " cg_sel"}, cg_sel, e_cg);
    chk({req, " shift"}, shift, e_sh);
    chk({req, " flags"}, {inc, ash, don, con, bon, func},
        {e_inc, e_s, e_d, e_c, e_b, e_func});
    chk({req, " drop"}, drop, e_drop);
  endtask

  task automatic do_ir(input logic [7:0] c, input string req);
    int n;
    pulse(0, c);
    model_ir(c);
    count_busy(n);
    chk({req, " R11 busy len"}, n, f_len(c));
    check_state(req);
  endtask

  task automatic do_wr(input logic [7:0] v, input string req);
    int n;
    pulse(1, v);
    if (e_cg) e_cgm[e_ac[5:0]] = v; else e_dd[e_ac] = v;
    if (e_s) e_sh = e_inc ? (e_sh + 1) % LLEN : (e_sh + LLEN - 1) % LLEN;
    e_ac = f_step(e_ac, e_inc, e_cg, e_func[2]);
    count_busy(n);
    chk({req, " R11 busy len"}, n, T_SHORT);
    check_state(req);
  endtask

  task automatic do_rd(input string req);
    int n;
    logic [7:0] exp;
    exp = e_cg ? e_cgm[e_ac[5:0]] : e_dd[e_ac];
    pulse(2, 8'h00);
    chk({req, " R7 read data"}, dr_data, exp);
    e_ac = f_step(e_ac, e_inc, e_cg, e_func[2]);
    count_busy(n);
    chk({req, " R11 busy len"}, n, T_MID);
    check_state(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int ok;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check_state("R1");
    chk("R1 busy", busy, 0);

    // R3 clear fills memory and resets state
    do_ir(8'h01, "R3 clear");
    ok = 1;
    for (int i = 0; i < 128; i++) if (mem_dd[i] != 8'h20) ok = 0;
    chk("R3 all DD = 0x20", ok, 1);

    // R5 field latches, R2 highest-bit decode (low bits are don't care)
    do_ir(8'h0F, "R5 R2 display control");
    do_ir(8'h07, "R5 R2 entry mode");
    do_ir(8'h06, "R5 entry mode");
    do_ir(8'h00, "R2 no-op");

    // R10 two-line boundaries with writes and cursor shifts
    do_ir(8'hA7, "R9 dd addr 0x27");
    do_wr(8'h5A, "R10 R6 0x27 to 0x40");
    do_ir(8'h10, "R8 R10 cursor left 0x40 to 0x27");
    do_ir(8'h80, "R9 dd addr 0x00");
    do_ir(8'h10, "R8 R10 cursor left 0x00 to 0x67");
    do_ir(8'h14, "R8 R10 cursor right 0x67 to 0x00");
    // four-line wrap
    do_ir(8'h3B, "R5 func four-line");
    do_ir(8'hFF, "R9 dd addr 0x7F");
    do_wr(8'h11, "R10 four-line 0x7F to 0x00");
    // CG wrap
    do_ir(8'h7F, "R9 cg addr 0x3F");
    do_wr(8'hC3, "R10 R6 cg 0x3F to 0x00");
    do_ir(8'h7F, "R9 cg addr 0x3F again");
    do_rd("R7 cg read back");
    // R13 shift wraps at both ends
    do_ir(8'h1C, "R8 R13 display right from 0");
    do_ir(8'h18, "R8 R13 display left back to 0");
    // R4 home
    do_ir(8'h1C, "R8 display shift");
    do_ir(8'h02, "R4 return home");

    // R12 requests during busy are ignored and counted
    pulse(0, 8'h01);
    model_ir(8'h01);
    pulse(0, 8'hD5);
    pulse(1, 8'h99);
    e_drop += 2;
    begin int n; count_busy(n); end
    check_state("R12 drop during busy");
    chk("R12 mem untouched", mem_dd[0], 8'h20);
    // simultaneous instruction and write: instruction wins
    @(negedge clk);
    ir_we = 1; ir_data = 8'h0C; dw_we = 1; dw_data = 8'h77;
    @(negedge clk);
    ir_we = 0; dw_we = 0;
    model_ir(8'h0C);
    e_drop += 1;
    begin int n; count_busy(n); chk("R12 R11 simultaneous busy", n, T_SHORT); end
    check_state("R12 simultaneous");
    chk("R12 write lost", mem_dd[0], 8'h20);

    // random mix
    for (int k = 0; k < 300; k++) begin
      int r;
      logic [7:0] rv;
      r = $urandom % 10;
      rv = 8'($urandom);
      case (r)
        0: do_ir(8'h04 | (rv & 8'h03), "R5 rnd entry");
        1: do_ir(8'h08 | (rv & 8'h07), "R5 rnd display");
        2: do_ir(8'h10 | (rv & 8'h0F), "R8 rnd shift");
        3: do_ir(8'h20 | (rv & 8'h1F), "R5 rnd func");
        4: do_ir(8'h40 | (rv & 8'h3F), "R9 rnd cg addr");
        5: do_ir(8'h80 | rv, "R9 rnd dd addr");
        6, 7: do_wr(rv, "R6 rnd write");
        8: do_rd("R7 rnd read");
        default: begin
          if (rv[4:0] == 0) do_ir(8'h01, "R3 rnd clear");
          else do_ir(8'h02, "R4 rnd home");
        end
      endcase
    end
    ok = 1;
    for (int i = 0; i < 128; i++) if (mem_dd[i] != e_dd[i]) ok = 0;
    for (int i = 0; i < 64; i++) if (mem_cg_a[i] != e_cgm[i]) ok = 0;
    chk("R6 R3 final memory image", ok, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule